// File: doc/BRIEF.md
# Multi-cycle processor control sequencer

This block is the hardwired controller of a small multi-cycle processor. Each clock cycle it looks at the opcode held in the instruction register and at the ALU zero flag. It then drives the datapath strobes for the current phase of execution. Those strobes are the ALU function code, the ALU second-operand select, the register-file write enable, the memory read and write enables, the write-back source select, the PC source select, the PC write enable and the instruction-register load.

Every instruction starts with a fetch phase and a decode phase. After decode, the opcode's class picks a fixed route:

- A load passes through execute, memory access and write-back.
- A store stops after memory access.
- An ALU operation skips memory access.
- A branch ends after execute.
- A halt parks the controller until reset.
- Opcodes with no assigned meaning do nothing and go straight back to fetch.

The current phase is exported so that the surrounding datapath, or a debugger, can see it. All strobes are decoded combinationally from the registered phase and the live opcode.

Top module: `mcyc_ctrl`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is held, the phase is fetch. On the first clock after release, the outputs are the fetch values. Phase codes: 0 fetch, 1 decode, 2 execute, 3 memory access, 4 write-back, 5 halted.
- R2: In fetch, the outputs are as follows:
  - `mem_rd_o`, `ir_we_o` and `pc_we_o` are 1.
  - `pc_src_o` is 0 (select PC+1).
  - All other strobes are 0, and `alu_op_o` is 0.
  - The next phase is always decode.
- R3: ALU opcodes are 2 add, 3 sub, 4 and, 5 or, 6 xor and 7 add-immediate. They take 4 cycles: fetch, decode, execute, write-back.
  - In execute, `alu_op_o` is 0 add, 1 sub, 2 and, 3 or, 4 xor. Add-immediate also uses code 0.
  - In execute, `alu_src_o` is 0 (register operand) for opcodes 2 to 6 and 1 (immediate) for opcode 7.
  - In write-back, `reg_we_o` is 1 and `mem_to_reg_o` is 0 (ALU result).
- R4: Load (opcode 0) takes 5 cycles.
  - Execute: `alu_op_o`=0 and `alu_src_o`=1.
  - Memory access: `mem_rd_o`=1.
  - Write-back: `reg_we_o`=1 and `mem_to_reg_o`=1 (memory data).
- R5: Store (opcode 1) takes 4 cycles: fetch, decode, execute, memory access.
  - Execute: `alu_op_o`=0 and `alu_src_o`=1.
  - Memory access: `mem_wr_o`=1.
  - `reg_we_o` is never asserted, and the instruction ends after memory access.
- R6: Branch-if-not-zero (opcode 8) takes 3 cycles.
  - In execute, `alu_op_o`=5 (pass first operand) and `alu_src_o`=0.
  - `pc_src_o` and `pc_we_o` are 1 only when `zero_i` is 0. When `zero_i` is 1, both stay 0.
  - `zero_i` has no effect on any output outside a branch's execute cycle.
- R7: Halt (opcode 15) goes fetch, decode, then halted. The halted phase asserts no enable, whatever the opcode and zero inputs, and is left only through reset.
- R8: Opcodes 9 to 14 return to fetch directly after decode. Decode never asserts any enable or select, for any opcode.
- R9: `mem_rd_o` and `mem_wr_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 4 | Opcode field of the instruction register |
| zero_i | input | 1 | ALU zero flag |
| alu_op_o | output | 3 | ALU function code |
| alu_src_o | output | 1 | ALU second operand: 0 register, 1 immediate |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Memory read enable |
| mem_wr_o | output | 1 | Memory write enable |
| mem_to_reg_o | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| pc_src_o | output | 1 | PC source: 0 PC+1, 1 branch target |
| pc_we_o | output | 1 | PC write enable |
| ir_we_o | output | 1 | Instruction-register load |
| phase_o | output | 3 | Current phase code |

## Verification
The bench builds the block with the package's fixed widths: a 4-bit opcode, a 3-bit ALU code and a 3-bit phase code. These widths make the whole opcode space small enough to cover exhaustively. The sequence runs every defined opcode and several undefined ones. It runs the branch with both zero-flag values, and with the zero flag set during non-branch execute cycles. It applies a reset in the middle of a load and sits in the halted phase while toggling both inputs. Each cycle, every strobe and the phase are compared with a behavioural model of the phase routes.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;
    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_MEM    = 3'd3,
        PH_WB     = 3'd4,
        PH_HALT   = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        IC_LOAD,
        IC_STORE,
        IC_ALU,
        IC_BRANCH,
        IC_HALT,
        IC_NOP
    } iclass_e;

    localparam logic [OPC_W-1:0] OPC_LOAD  = OPC_W'(0);
    localparam logic [OPC_W-1:0] OPC_STORE = OPC_W'(1);
    localparam logic [OPC_W-1:0] OPC_ADD   = OPC_W'(2);
    localparam logic [OPC_W-1:0] OPC_SUB   = OPC_W'(3);
    localparam logic [OPC_W-1:0] OPC_AND   = OPC_W'(4);
    localparam logic [OPC_W-1:0] OPC_OR    = OPC_W'(5);
    localparam logic [OPC_W-1:0] OPC_XOR   = OPC_W'(6);
    localparam logic [OPC_W-1:0] OPC_ADDI  = OPC_W'(7);
    localparam logic [OPC_W-1:0] OPC_BNZ   = OPC_W'(8);
    localparam logic [OPC_W-1:0] OPC_HALT  = {OPC_W{1'b1}};

    localparam logic [ALUOP_W-1:0] ALU_ADD  = ALUOP_W'(0);
    localparam logic [ALUOP_W-1:0] ALU_SUB  = ALUOP_W'(1);
    localparam logic [ALUOP_W-1:0] ALU_AND  = ALUOP_W'(2);
    localparam logic [ALUOP_W-1:0] ALU_OR   = ALUOP_W'(3);
    localparam logic [ALUOP_W-1:0] ALU_XOR  = ALUOP_W'(4);
    localparam logic [ALUOP_W-1:0] ALU_PASS = ALUOP_W'(5);

    typedef struct packed {
        iclass_e              cls;
        logic [ALUOP_W-1:0]   alu_op;
        logic                 alu_src;
    } dec_t;

    typedef struct packed {
        logic [ALUOP_W-1:0]   alu_op;
        logic                 alu_src;
        logic                 reg_we;
        logic                 mem_rd;
        logic                 mem_wr;
        logic                 mem_to_reg;
        logic                 pc_src;
        logic                 pc_we;
        logic                 ir_we;
    } ctl_t;

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output dec_t             dec_o
);

    always_comb begin
        dec_o = '{cls: IC_NOP, alu_op: ALU_ADD, alu_src: 1'b0};
        case (opcode_i)
            OPC_LOAD:  dec_o = '{cls: IC_LOAD,   alu_op: ALU_ADD,  alu_src: 1'b1};
            OPC_STORE: dec_o = '{cls: IC_STORE,  alu_op: ALU_ADD,  alu_src: 1'b1};
            OPC_ADD:   dec_o = '{cls: IC_ALU,    alu_op: ALU_ADD,  alu_src: 1'b0};
            OPC_SUB:   dec_o = '{cls: IC_ALU,    alu_op: ALU_SUB,  alu_src: 1'b0};
            OPC_AND:   dec_o = '{cls: IC_ALU,    alu_op: ALU_AND,  alu_src: 1'b0};
            OPC_OR:    dec_o = '{cls: IC_ALU,    alu_op: ALU_OR,   alu_src: 1'b0};
            OPC_XOR:   dec_o = '{cls: IC_ALU,    alu_op: ALU_XOR,  alu_src: 1'b0};
            OPC_ADDI:  dec_o = '{cls: IC_ALU,    alu_op: ALU_ADD,  alu_src: 1'b1};
            OPC_BNZ:   dec_o = '{cls: IC_BRANCH, alu_op: ALU_PASS, alu_src: 1'b0};
            OPC_HALT:  dec_o = '{cls: IC_HALT,   alu_op: ALU_ADD,  alu_src: 1'b0};
            default:   dec_o = '{cls: IC_NOP,    alu_op: ALU_ADD,  alu_src: 1'b0};
        endcase
    end

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
    import mcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  iclass_e cls_i,
    output phase_e  phase_o
);

    typedef struct packed {
        phase_e phase;
    } seq_s;

    seq_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.phase)
            PH_FETCH:  s_d.phase = PH_DECODE;
            PH_DECODE: begin
                case (cls_i)
                    IC_HALT: s_d.phase = PH_HALT;
                    IC_NOP:  s_d.phase = PH_FETCH;
                    default: s_d.phase = PH_EXEC;
                endcase
            end
            PH_EXEC: begin
                case (cls_i)
                    IC_LOAD, IC_STORE: s_d.phase = PH_MEM;
                    IC_ALU:            s_d.phase = PH_WB;
                    default:           s_d.phase = PH_FETCH;
                endcase
            end
            PH_MEM:    s_d.phase = (cls_i == IC_LOAD) ? PH_WB : PH_FETCH;
            PH_WB:     s_d.phase = PH_FETCH;
            PH_HALT:   s_d.phase = PH_HALT;
            default:   s_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FETCH};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;

    a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_FETCH) |=> (s_q.phase == PH_DECODE));

    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_HALT) |=> (s_q.phase == PH_HALT));

    a_r5_store_ends_after_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_MEM && cls_i == IC_STORE) |=> (s_q.phase == PH_FETCH));

endmodule

// File: rtl/mcc_drive.sv
module mcc_drive
    import mcc_pkg::*;
(
    input  phase_e phase_i,
    input  dec_t   dec_i,
    input  logic   zero_i,
    output ctl_t   ctl_o
);

    always_comb begin
        ctl_o = '0;
        case (phase_i)
            PH_FETCH: begin
                ctl_o.mem_rd = 1'b1;
                ctl_o.ir_we  = 1'b1;
                ctl_o.pc_we  = 1'b1;
                ctl_o.pc_src = 1'b0;
            end
            PH_EXEC: begin
                ctl_o.alu_op  = dec_i.alu_op;
                ctl_o.alu_src = dec_i.alu_src;
                if (dec_i.cls == IC_BRANCH && !zero_i) begin
                    ctl_o.pc_src = 1'b1;
                    ctl_o.pc_we  = 1'b1;
                end
            end
            PH_MEM: begin
                ctl_o.mem_rd = (dec_i.cls == IC_LOAD);
                ctl_o.mem_wr = (dec_i.cls == IC_STORE);
            end
            PH_WB: begin
                ctl_o.reg_we     = 1'b1;
                ctl_o.mem_to_reg = (dec_i.cls == IC_LOAD);
            end
            default: ctl_o = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPC_W-1:0]    opcode_i,
    input  logic                zero_i,
    output logic [ALUOP_W-1:0]  alu_op_o,
    output logic                alu_src_o,
    output logic                reg_we_o,
    output logic                mem_rd_o,
    output logic                mem_wr_o,
    output logic                mem_to_reg_o,
    output logic                pc_src_o,
    output logic                pc_we_o,
    output logic                ir_we_o,
    output logic [PHASE_W-1:0]  phase_o
);

    dec_t   dec;
    phase_e phase;
    ctl_t   ctl;

    mcc_decode u_decode (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    mcc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .cls_i   (dec.cls),
        .phase_o (phase)
    );

    mcc_drive u_drive (
        .phase_i (phase),
        .dec_i   (dec),
        .zero_i  (zero_i),
        .ctl_o   (ctl)
    );

    assign alu_op_o     = ctl.alu_op;
    assign alu_src_o    = ctl.alu_src;
    assign reg_we_o     = ctl.reg_we;
    assign mem_rd_o     = ctl.mem_rd;
    assign mem_wr_o     = ctl.mem_wr;
    assign mem_to_reg_o = ctl.mem_to_reg;
    assign pc_src_o     = ctl.pc_src;
    assign pc_we_o      = ctl.pc_we;
    assign ir_we_o      = ctl.ir_we;
    assign phase_o      = phase;

    a_r9_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    a_r7_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HALT) |-> !(reg_we_o || mem_rd_o || mem_wr_o || pc_we_o || ir_we_o));

    a_r6_zero_blocks_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && opcode_i == OPC_BNZ && zero_i) |-> !pc_we_o);

    a_r8_decode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |-> !(reg_we_o || mem_rd_o || mem_wr_o || pc_we_o || ir_we_o));

    a_r4_load_reaches_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_MEM && opcode_i == OPC_LOAD) |=> (phase == PH_WB && mem_to_reg_o));

endmodule

// File: tb/mcyc_ctrl_bench.sv
module mcyc_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opcode_i = 4'd0;
    logic       zero_i = 1'b0;
    logic [2:0] alu_op_o;
    logic       alu_src_o, reg_we_o, mem_rd_o, mem_wr_o, mem_to_reg_o;
    logic       pc_src_o, pc_we_o, ir_we_o;
    logic [2:0] phase_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int ops[$];
    bit zs[$];
    int m_ph = 0;
    int m_op = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcyc_ctrl u_mcyc_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .opcode_i     (opcode_i),
        .zero_i       (zero_i),
        .alu_op_o     (alu_op_o),
        .alu_src_o    (alu_src_o),
        .reg_we_o     (reg_we_o),
        .mem_rd_o     (mem_rd_o),
        .mem_wr_o     (mem_wr_o),
        .mem_to_reg_o (mem_to_reg_o),
        .pc_src_o     (pc_src_o),
        .pc_we_o      (pc_we_o),
        .ir_we_o      (ir_we_o),
        .phase_o      (phase_o)
    );

    // Packed as {alu_op, alu_src, reg_we, mem_rd, mem_wr, mem_to_reg, pc_src, pc_we, ir_we, phase}
    function automatic logic [13:0] model_out(int ph, int op, bit z);
        logic [2:0] aop = 3'd0;
        bit asrc = 0, rwe = 0, mrd = 0, mwr = 0, mtr = 0, psrc = 0, pwe = 0, irw = 0;
        if (ph == 0) begin
            mrd = 1; irw = 1; pwe = 1;
        end else if (ph == 2) begin
            if (op == 0 || op == 1 || op == 7) asrc = 1;
            if (op >= 3 && op <= 6) aop = 3'(op - 2);
            if (op == 8) begin
                aop = 3'd5;
                if (!z) begin psrc = 1; pwe = 1; end
            end
        end else if (ph == 3) begin
            mrd = (op == 0);
            mwr = (op == 1);
        end else if (ph == 4) begin
            rwe = 1;
            mtr = (op == 0);
        end
        return {aop, asrc, rwe, mrd, mwr, mtr, psrc, pwe, irw, 3'(ph)};
    endfunction

    function automatic int model_next(int ph, int op);
        case (ph)
            0: return 1;
            1: return (op == 15) ? 5 : (op <= 8) ? 2 : 0;
            2: return (op <= 1) ? 3 : (op <= 7) ? 4 : 0;
            3: return (op == 0) ? 4 : 0;
            4: return 0;
            default: return 5;
        endcase
    endfunction

    function automatic string req_of(int ph, int op);
        if (ph == 0) return "R2";
        if (ph == 5) return "R7";
        if (ph == 1) return (op == 15) ? "R7" : "R8";
        if (op == 0) return "R4";
        if (op == 1) return "R5";
        if (op >= 2 && op <= 7) return "R3";
        if (op == 8) return "R6";
        return "R8";
    endfunction

    task automatic compare(string req);
        logic [13:0] act, exp_v;
        act   = {alu_op_o, alu_src_o, reg_we_o, mem_rd_o, mem_wr_o, mem_to_reg_o,
                 pc_src_o, pc_we_o, ir_we_o, phase_o};
        exp_v = model_out(m_ph, m_op, zero_i);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: phase %0d opcode %0d zero %0b actual=%b expected=%b",
                     req, m_ph, m_op, zero_i, act, exp_v);
        end
        checks++;
        if (mem_rd_o && mem_wr_o) begin
            errors++;
            $display("FAIL R9: read and write together actual=11 expected=not both");
        end
    endtask

    task automatic step();
        int  nxt;
        bit  was_fetch;
        @(negedge clk);
        compare(req_of(m_ph, m_op));
        nxt = model_next(m_ph, m_op);
        was_fetch = (m_ph == 0);
        @(posedge clk);
        #1;
        if (was_fetch && ops.size() > 0) begin
            m_op = ops.pop_front();
            opcode_i = 4'(m_op);
            zero_i = zs.pop_front();
        end
        m_ph = nxt;
    endtask

    task automatic run_queue();
        while (ops.size() > 0 || (m_ph != 0 && m_ph != 5)) step();
    endtask

    task automatic push(int op, bit z);
        ops.push_back(op);
        zs.push_back(z);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        m_ph = 0;
        @(negedge clk);
        compare("R1");
        @(negedge clk);
        compare("R1");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        apply_reset();
        // R1: first cycle after release shows fetch strobes
        // R3, R4, R5 with zero flag set in non-branch execute (R6 no effect there)
        push(0, 0); push(1, 1); push(2, 1); push(3, 0); push(4, 0);
        push(5, 1); push(6, 0); push(7, 1);
        // R6 taken and not taken
        push(8, 0); push(8, 1);
        // R8 unassigned opcodes
        push(9, 0); push(12, 1); push(14, 0);
        run_queue();
        // R1: reset in the middle of a load, during its execute cycle
        push(0, 0);
        step(); step();
        apply_reset();
        push(1, 0); push(8, 0); push(11, 1);
        // R7 halt, then hold halted while inputs toggle
        push(15, 0);
        run_queue();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            compare("R7");
            @(posedge clk);
            #1;
            opcode_i = 4'(i);
            m_op = i;
            zero_i = i[0];
        end
        // R1: reset releases the halted state
        apply_reset();
        push(2, 0); push(15, 1);
        run_queue();
        step(); step();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d cycles expected=under %0d", cycles, WATCHDOG);
                summary();
                $finish;
            end
        end
    end

endmodule